// File: doc/BRIEF.md
# Floating-Point Register Stack Top and Tag Tracker

This block keeps the stack-top pointer and the per-slot tag word of an eight-entry floating-point register stack. Micro-operations that push or pop the stack present a valid strobe, a signed displacement and a per-operation tag-update enable. In a single cycle the block computes the new top and, when enabled, marks every slot that the move uncovers as empty or every slot that it newly covers as valid. Wraparound modulo the stack depth is handled, and several slots can change in one step.

The block also takes direct architectural writes of the tag word and of the top. These are used when state is restored from memory or handed over from another execution engine. The block generates only two tag codes, valid and empty. Deciding whether a value is zero or special is left to other logic, and so is the arithmetic.

Top module: `fpstk_tag_tracker`

## Requirements
- R1: After synchronous reset the top reads 0 and the tag word reads 0xFFFF. Slot i occupies tag bits 2i+1:2i, and the empty code is 2'b11.
- R2: An accepted operation with a legal displacement d sets the top to (top + d) mod 8 on the clock edge that samples the strobe.
- R3: With tag update enabled and d > 0 (a pop), the d slots starting at the old top and going upward modulo 8 become empty (2'b11).
- R4: With tag update enabled and d < 0 (a push), the slots from the new top up to the old top, not including the old top, become valid (2'b00).
- R5: Slot ranges that cross slot 7 wrap to slot 0.
- R6: Tag pairs of slots outside the affected range keep their previous values.
- R7: With the tag-update enable low, a moving operation changes only the top.
- R8: A displacement of 0, or the out-of-range code -8 (4'b1000), leaves both the top and the tag word unchanged.
- R9: An architectural write of the tag word or of the top, in the same cycle as an operation, loads the written value and discards the operation completely. A top write leaves the tag word unchanged, and a tag write leaves the top unchanged.
- R10: The done output pulses high for one cycle after each accepted operation, and it stays low when the strobe is low or when a write discards the operation. With the strobe low, the displacement has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Micro-operation strobe |
| op_disp | input | 4 | Signed stack displacement, -7..+7 |
| op_tag_en | input | 1 | Apply a tag update along with the move |
| wr_tag_en | input | 1 | Architectural tag-word write enable |
| wr_tag_data | input | 16 | Tag word to load |
| wr_top_en | input | 1 | Architectural top write enable |
| wr_top_data | input | 3 | Top value to load |
| stk_top | output | 3 | Current stack top |
| tag_word | output | 16 | Current tag word |
| op_done | output | 1 | Pulse marking a completed operation |

## Verification
The bench builds the block with its default depth of eight slots, which gives a 4-bit displacement and a 16-bit tag word. At that depth the largest moves (+7 and -7) reach every slot but one, so a single step shows both wraparound and the preservation of the untouched slot. The code -8 is the only out-of-range value, and it falls inside the 4-bit field the bench can drive. A cumulative table of pushes and pops walks the top fully around the ring. Directed cases then cover write priority, idle strobes and a mid-run reset.

// File: rtl/fpstk_pkg.sv
package fpstk_pkg;
  localparam int TAG_W = 2;
  typedef logic [TAG_W-1:0] tag_t;
  localparam tag_t TAG_VALID = 2'b00;
  localparam tag_t TAG_EMPTY = 2'b11;
endpackage

// File: rtl/fpstk_disp_decode.sv
module fpstk_disp_decode #(
  parameter int SLOTS = 8,
  localparam int PTR_W = $clog2(SLOTS),
  localparam int DISP_W = PTR_W + 1
) (
  input  logic [PTR_W-1:0]         cur_top,
  input  logic signed [DISP_W-1:0] disp,
  output logic                     legal,
  output logic                     is_pop,
  output logic                     is_push,
  output logic [PTR_W-1:0]         next_top,
  output logic [SLOTS-1:0]         slot_hit
);
  localparam logic [DISP_W-1:0] MOST_NEG = {1'b1, {(DISP_W-1){1'b0}}};
  localparam logic [DISP_W-1:0] DEPTH    = DISP_W'(SLOTS);

  logic [DISP_W-1:0] mag;

  always_comb begin
    legal    = (disp != MOST_NEG);
    is_pop   = legal && !disp[DISP_W-1] && (disp != '0);
    is_push  = legal && disp[DISP_W-1];
    mag      = disp[DISP_W-1] ? DISP_W'(-disp) : DISP_W'(disp);
    next_top = cur_top + disp[PTR_W-1:0];
  end

  // each slot decides from its distance above the current top
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic [PTR_W-1:0] ofs;
    always_comb begin
      ofs = PTR_W'(s) - cur_top;
      if (is_pop)
        slot_hit[s] = ({1'b0, ofs} < mag);
      else if (is_push)
        slot_hit[s] = ({1'b0, ofs} >= (DEPTH - mag));
      else
        slot_hit[s] = 1'b0;
    end
  end

  // the number of touched slots must equal the move size (R3, R4)
  always_comb begin
    if (is_pop || is_push)
      p_hit_count_r3: assert ($countones(slot_hit) == int'(mag));
  end
endmodule

// File: rtl/fpstk_tag_merge.sv
module fpstk_tag_merge
  import fpstk_pkg::*;
#(
  parameter int SLOTS = 8,
  localparam int WORD_W = SLOTS * TAG_W
) (
  input  logic [WORD_W-1:0] tag_in,
  input  logic [SLOTS-1:0]  slot_hit,
  input  logic              fill_empty,
  output logic [WORD_W-1:0] tag_out
);
  for (genvar s = 0; s < SLOTS; s++) begin : g_pair
    always_comb begin
      if (slot_hit[s])
        tag_out[s*TAG_W +: TAG_W] = fill_empty ? TAG_EMPTY : TAG_VALID;
      else
        tag_out[s*TAG_W +: TAG_W] = tag_in[s*TAG_W +: TAG_W];
    end
  end
endmodule

// File: rtl/fpstk_tag_tracker.sv
module fpstk_tag_tracker
  import fpstk_pkg::*;
#(
  parameter int SLOTS = 8,
  localparam int PTR_W = $clog2(SLOTS),
  localparam int DISP_W = PTR_W + 1,
  localparam int WORD_W = SLOTS * TAG_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     op_valid,
  input  logic signed [DISP_W-1:0] op_disp,
  input  logic                     op_tag_en,
  input  logic                     wr_tag_en,
  input  logic [WORD_W-1:0]        wr_tag_data,
  input  logic                     wr_top_en,
  input  logic [PTR_W-1:0]         wr_top_data,
  output logic [PTR_W-1:0]         stk_top,
  output logic [WORD_W-1:0]        tag_word,
  output logic                     op_done
);
  logic             accept;
  logic             legal, is_pop, is_push;
  logic [PTR_W-1:0] next_top;
  logic [SLOTS-1:0] slot_hit;
  logic [WORD_W-1:0] merged;

  assign accept = op_valid && !wr_tag_en && !wr_top_en;

  fpstk_disp_decode #(.SLOTS(SLOTS)) u_dec (
    .cur_top (stk_top),
    .disp    (op_disp),
    .legal   (legal),
    .is_pop  (is_pop),
    .is_push (is_push),
    .next_top(next_top),
    .slot_hit(slot_hit)
  );

  fpstk_tag_merge #(.SLOTS(SLOTS)) u_merge (
    .tag_in    (tag_word),
    .slot_hit  (slot_hit),
    .fill_empty(is_pop),
    .tag_out   (merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      stk_top  <= '0;
      tag_word <= '1;
      op_done  <= 1'b0;
    end else begin
      op_done <= accept;
      if (wr_tag_en)
        tag_word <= wr_tag_data;
      else if (accept && op_tag_en && (is_pop || is_push))
        tag_word <= merged;
      if (wr_top_en)
        stk_top <= wr_top_data;
      else if (accept && legal)
        stk_top <= next_top;
    end
  end

  p_reset_state_r1: assert property (@(posedge clk)
    $past(rst) |-> (stk_top == '0 && tag_word == '1));

  p_pop_only_sets_r3: assert property (@(posedge clk) disable iff (rst)
    (accept && op_disp > 0) |=> (($past(tag_word) & ~tag_word) == '0));

  p_push_only_clears_r4: assert property (@(posedge clk) disable iff (rst)
    (accept && op_disp < 0) |=> ((~$past(tag_word) & tag_word) == '0));

  p_no_tag_en_r7: assert property (@(posedge clk) disable iff (rst)
    (accept && !op_tag_en) |=> $stable(tag_word));

  p_zero_disp_r8: assert property (@(posedge clk) disable iff (rst)
    (accept && op_disp == '0) |=> ($stable(tag_word) && $stable(stk_top)));

  p_tag_write_wins_r9: assert property (@(posedge clk) disable iff (rst)
    wr_tag_en |=> (tag_word == $past(wr_tag_data)));

  p_top_write_wins_r9: assert property (@(posedge clk) disable iff (rst)
    wr_top_en |=> (stk_top == $past(wr_top_data)));

  p_done_source_r10: assert property (@(posedge clk) disable iff (rst)
    op_done |-> $past(op_valid));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!op_valid && !wr_tag_en && !wr_top_en) |=>
      ($stable(tag_word) && $stable(stk_top) && !op_done));
endmodule

// File: tb/fpstk_tag_tracker_test.sv
module fpstk_tag_tracker_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        op_valid, op_tag_en, wr_tag_en, wr_top_en;
  logic [3:0]  op_disp;
  logic [15:0] wr_tag_data;
  logic [2:0]  wr_top_data;
  logic [2:0]  stk_top;
  logic [15:0] tag_word;
  logic        op_done;
  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  fpstk_tag_tracker uut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_disp(op_disp),
    .op_tag_en(op_tag_en), .wr_tag_en(wr_tag_en), .wr_tag_data(wr_tag_data),
    .wr_top_en(wr_top_en), .wr_top_data(wr_top_data),
    .stk_top(stk_top), .tag_word(tag_word), .op_done(op_done)
  );

  // {disp[3:0], tag_en, exp_top[2:0], exp_tag[15:0]}, applied in sequence
  localparam int NV = 12;
  localparam logic [23:0] VEC [NV] = '{
    {4'hD, 1'b1, 3'd5, 16'h03FF},
    {4'hE, 1'b1, 3'd3, 16'h003F},
    {4'hC, 1'b1, 3'd7, 16'h0000},
    {4'h2, 1'b1, 3'd1, 16'hC003},
    {4'h1, 1'b0, 3'd2, 16'hC003},
    {4'h0, 1'b1, 3'd2, 16'hC003},
    {4'h4, 1'b1, 3'd6, 16'hCFF3},
    {4'h7, 1'b0, 3'd5, 16'hCFF3},
    {4'h9, 1'b1, 3'd6, 16'h0C00},
    {4'h8, 1'b1, 3'd6, 16'h0C00},
    {4'h7, 1'b1, 3'd5, 16'hFFFF},
    {4'hF, 1'b1, 3'd4, 16'hFCFF}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    op_valid = 0; op_disp = 0; op_tag_en = 0;
    wr_tag_en = 0; wr_tag_data = 0; wr_top_en = 0; wr_top_data = 0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    idle();
    rst = 1;
    step(); step();
    rst = 0;
    // R1 reset state
    check("R1 top", 32'(stk_top), 32'd0);
    check("R1 tag", 32'(tag_word), 32'hFFFF);
    check("R10 done idle", 32'(op_done), 32'd0);

    // table walk: R2 R3 R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      op_valid = 1; op_disp = VEC[i][23:20]; op_tag_en = VEC[i][19];
      step();
      idle();
      check($sformatf("R2/R5 top vec%0d", i), 32'(stk_top), 32'(VEC[i][18:16]));
      check($sformatf("R3/R4/R6/R7/R8 tag vec%0d", i), 32'(tag_word), 32'(VEC[i][15:0]));
      check($sformatf("R10 done vec%0d", i), 32'(op_done), 32'd1);
      step();
      check($sformatf("R10 done drops vec%0d", i), 32'(op_done), 32'd0);
    end

    // R10 strobe low: displacement ignored (state top 4, tag FCFF)
    op_disp = 4'h3; op_tag_en = 1;
    step();
    idle();
    check("R10 idle top", 32'(stk_top), 32'd4);
    check("R10 idle tag", 32'(tag_word), 32'hFCFF);

    // R9 tag write beats a pop: top stays 4
    op_valid = 1; op_disp = 4'h2; op_tag_en = 1;
    wr_tag_en = 1; wr_tag_data = 16'h1234;
    step();
    idle();
    check("R9 tag loaded", 32'(tag_word), 32'h1234);
    check("R9 top kept", 32'(stk_top), 32'd4);
    check("R9 done low", 32'(op_done), 32'd0);

    // R9 top write beats a push: tag stays 1234
    op_valid = 1; op_disp = 4'hE; op_tag_en = 1;
    wr_top_en = 1; wr_top_data = 3'd1;
    step();
    idle();
    check("R9 top loaded", 32'(stk_top), 32'd1);
    check("R9 tag kept", 32'(tag_word), 32'h1234);
    check("R9 done low top", 32'(op_done), 32'd0);

    // R5 pop from slot 7 wrapping to 0: top 7, pop 2 -> slots 7,0 empty
    wr_top_en = 1; wr_top_data = 3'd7; wr_tag_en = 1; wr_tag_data = 16'h0000;
    step();
    idle();
    op_valid = 1; op_disp = 4'h2; op_tag_en = 1;
    step();
    idle();
    check("R5 wrap top", 32'(stk_top), 32'd1);
    check("R5 wrap tag", 32'(tag_word), 32'hC003);

    // R1 reset mid-run
    rst = 1;
    step();
    rst = 0;
    check("R1 re-reset top", 32'(stk_top), 32'd0);
    check("R1 re-reset tag", 32'(tag_word), 32'hFFFF);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule